// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links an A-side and a B-side data bus inside a chip. Every bus pin is split into separate input, output and output-enable signals, so the surrounding logic (or the bench) resolves each bus. The data path is cut into independent halves, each with its own control set. Every half has two directions. Each direction holds one storage register, loaded from its source bus. A select input picks whether the opposite bus receives live data or the stored word. The A-to-B enable is active high and the B-to-A enable is active low.

Capture strobes are sampled on the rising edge of a common clock `clk`. A direction loads its register on every edge where its strobe is high, whatever its select and enable are. Because the B register always samples the B input, it can take in the value this block itself drives onto B. One A word can therefore be loaded into both registers on a single edge. With both directions live and no other driver present, the two buses reinforce each other and keep their last value. The design holds no state machine. The only state is the two storage registers per half, each with two states: hold and load.

Top module: `bus_xcvr_reg`

## Requirements
- R1: In each half, `b_oe` is high exactly when that half's `ab_en` is 1. While `b_oe` is 0, the half's `b_out` bits are 0.
- R2: In each half, `a_oe` is high exactly when that half's `ba_en_n` is 0. While `a_oe` is 0, the half's `a_out` bits are 0.
- R3: With a direction enabled, a select of 0 sends the opposite bus input to the output in the same cycle. A select of 1 sends that direction's register. A select change moves the output straight from one source to the other within the cycle.
- R4: On a `clk` rising edge with `ab_cap` high, the half's A register takes `a_in`, regardless of selects and enables. Otherwise it holds its value. This includes the case where the A bus is being driven from the B register.
- R5: On a `clk` rising edge with `ba_cap` high, the half's B register takes `b_in`, regardless of selects and enables. Otherwise it holds its value.
- R6: While A-to-B is live (`ab_en`=1, `ab_sel`=0), strobing both captures on one edge loads the same A word into both registers.
- R7: With both directions enabled, both selects 0 and no outside driver, `b_out` follows `a_in` and `a_out` follows `b_in`. The resolved buses therefore keep their last value.
- R8: The halves are independent. Half h (bits 8h+7..8h) reacts only to control bit h.
- R9: Driving `rst_n` low clears every storage register to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low clear of the registers |
| a_in | input | 16 | Resolved A bus value |
| a_out | output | 16 | Value driven onto the A bus |
| a_oe | output | 2 | A bus drive enable, one per half |
| b_in | input | 16 | Resolved B bus value |
| b_out | output | 16 | Value driven onto the B bus |
| b_oe | output | 2 | B bus drive enable, one per half |
| ab_cap | input | 2 | Load A register on next edge, per half |
| ab_sel | input | 2 | A-to-B source: 0 live, 1 stored |
| ab_en | input | 2 | A-to-B drive enable, active high |
| ba_cap | input | 2 | Load B register on next edge, per half |
| ba_sel | input | 2 | B-to-A source: 0 live, 1 stored |
| ba_en_n | input | 2 | B-to-A drive enable, active low |

## Verification
The register properties assume that the capture strobes and data inputs are steady around the clock edge. The bench changes inputs only on the falling edge and lets the bus resolution loop settle well before the next rising edge. Two captures in stored mode are never strobed together, because each would load what the other register is driving. The bench staggers such loads by one cycle. In the mutual live case, the bench avoids an unresolved loop: it either holds an outside driver on A or enters the case from a bus state in which both sides already agree.

// File: rtl/bxr_pkg.sv
`timescale 1ns/100ps
package bxr_pkg;
    typedef struct packed {
        logic cap;   // load the direction register on the next edge
        logic sel;   // 0 live, 1 stored
        logic en;    // raw enable, polarity set per direction
    } dir_ctrl_t;
endpackage

// File: rtl/bxr_store.sv
`timescale 1ns/100ps
module bxr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_STORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d)); // R4 R5

    AST_STORE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R4 R5

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_STORE_RESET: assert (q == '0); // R9
        end
    end
endmodule

// File: rtl/bxr_path.sv
`timescale 1ns/100ps
module bxr_path
    import bxr_pkg::*;
#(
    parameter int W       = 8,
    parameter bit EN_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_in,
    input  dir_ctrl_t    ctrl,
    output logic [W-1:0] dst_out,
    output logic         dst_oe
);
    logic [W-1:0] held;

    bxr_store #(.W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctrl.cap),
        .d     (src_in),
        .q     (held)
    );

    generate
        if (EN_HIGH) begin : g_en_hi
            assign dst_oe = ctrl.en;
        end else begin : g_en_lo
            assign dst_oe = ~ctrl.en;
        end
    endgenerate

    // one level of selection: each bit is taken from exactly one source
    always_comb begin
        if (!dst_oe)
            dst_out = '0;
        else if (ctrl.sel)
            dst_out = held;
        else
            dst_out = src_in;
    end

    AST_PATH_STORED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_oe && ctrl.sel && !ctrl.cap) ##1 (dst_oe && ctrl.sel) |-> $stable(dst_out)); // R3
endmodule

// File: rtl/bxr_half.sv
`timescale 1ns/100ps
module bxr_half
    import bxr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  dir_ctrl_t    ab_ctrl,
    input  dir_ctrl_t    ba_ctrl,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    bxr_path #(.W(W), .EN_HIGH(1'b1)) u_ab (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (a_in),
        .ctrl    (ab_ctrl),
        .dst_out (b_out),
        .dst_oe  (b_oe)
    );

    bxr_path #(.W(W), .EN_HIGH(1'b0)) u_ba (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (b_in),
        .ctrl    (ba_ctrl),
        .dst_out (a_out),
        .dst_oe  (a_oe)
    );
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/100ps
module bus_xcvr_reg
    import bxr_pkg::*;
#(
    parameter int HALVES = 2,
    parameter int HALF_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HALVES*HALF_W-1:0] a_in,
    output logic [HALVES*HALF_W-1:0] a_out,
    output logic [HALVES-1:0]        a_oe,
    input  logic [HALVES*HALF_W-1:0] b_in,
    output logic [HALVES*HALF_W-1:0] b_out,
    output logic [HALVES-1:0]        b_oe,
    input  logic [HALVES-1:0]        ab_cap,
    input  logic [HALVES-1:0]        ab_sel,
    input  logic [HALVES-1:0]        ab_en,
    input  logic [HALVES-1:0]        ba_cap,
    input  logic [HALVES-1:0]        ba_sel,
    input  logic [HALVES-1:0]        ba_en_n
);
    localparam int TOTAL_W = HALVES * HALF_W;

    generate
        for (genvar g = 0; g < HALVES; g++) begin : g_half
            dir_ctrl_t ab_c;
            dir_ctrl_t ba_c;
            assign ab_c = '{cap: ab_cap[g], sel: ab_sel[g], en: ab_en[g]};
            assign ba_c = '{cap: ba_cap[g], sel: ba_sel[g], en: ba_en_n[g]};

            bxr_half #(.W(HALF_W)) u_half (
                .clk     (clk),
                .rst_n   (rst_n),
                .a_in    (a_in[g*HALF_W +: HALF_W]),
                .b_in    (b_in[g*HALF_W +: HALF_W]),
                .ab_ctrl (ab_c),
                .ba_ctrl (ba_c),
                .a_out   (a_out[g*HALF_W +: HALF_W]),
                .a_oe    (a_oe[g]),
                .b_out   (b_out[g*HALF_W +: HALF_W]),
                .b_oe    (b_oe[g])
            );
        end
    endgenerate

    initial begin
        if (TOTAL_W != HALVES * HALF_W) $error("width mismatch");
    end
endmodule

// File: tb/bus_xcvr_reg_test.sv
`timescale 1ns/100ps
module bus_xcvr_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe;
    logic [1:0]  ab_cap = '0, ab_sel = '0, ab_en = '0;
    logic [1:0]  ba_cap = '0, ba_sel = '0, ba_en_n = 2'b11;

    logic [15:0] ext_a = '0, ext_b = '0, hold_a = '0, hold_b = '0;
    logic [1:0]  ext_a_on = '0, ext_b_on = '0;
    logic [7:0]  ma [2];
    logic [7:0]  mb [2];
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_xcvr_reg uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_cap(ab_cap), .ab_sel(ab_sel), .ab_en(ab_en),
        .ba_cap(ba_cap), .ba_sel(ba_sel), .ba_en_n(ba_en_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus resolution: outside driver, else block driver, else last value
    task automatic settle();
        logic [15:0] na, nb;
        repeat (4) begin
            for (int h = 0; h < 2; h++) begin
                na[h*8 +: 8] = ext_a_on[h] ? ext_a[h*8 +: 8] :
                               (a_oe[h] ? a_out[h*8 +: 8] : hold_a[h*8 +: 8]);
                nb[h*8 +: 8] = ext_b_on[h] ? ext_b[h*8 +: 8] :
                               (b_oe[h] ? b_out[h*8 +: 8] : hold_b[h*8 +: 8]);
            end
            a_in = na;
            b_in = nb;
            #0.1;
        end
        hold_a = a_in;
        hold_b = b_in;
    endtask

    task automatic capture(input logic [1:0] m_ab, input logic [1:0] m_ba);
        @(negedge clk);
        ab_cap = m_ab;
        ba_cap = m_ba;
        @(posedge clk);
        for (int h = 0; h < 2; h++) begin
            if (m_ab[h]) ma[h] = a_in[h*8 +: 8];
            if (m_ba[h]) mb[h] = b_in[h*8 +: 8];
        end
        @(negedge clk);
        ab_cap = '0;
        ba_cap = '0;
        settle();
    endtask

    function automatic void expect_bus(input logic en, input logic enn, input logic sab,
                                       input logic sba, input logic [7:0] ea, input logic [7:0] eb,
                                       input logic [7:0] ra, input logic [7:0] rb,
                                       output logic [7:0] xa, output logic [7:0] xb);
        logic adrv, bdrv;
        adrv = !enn;
        bdrv = en;
        if (adrv && bdrv && !sab && !sba) begin xa = ea; xb = ea; end
        else if (adrv && bdrv) begin xa = sba ? rb : ra; xb = sab ? ra : rb; end
        else if (bdrv) begin xa = ea; xb = sab ? ra : ea; end
        else if (adrv) begin xb = eb; xa = sba ? rb : eb; end
        else begin xa = ea; xb = eb; end
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] xa, xb;
        ma[0] = 0; ma[1] = 0; mb[0] = 0; mb[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1 reset b_oe", {6'b0, b_oe}, 8'h00);
        check("R2 reset a_oe", {6'b0, a_oe}, 8'h00);
        check("R1 reset b_out", b_out[7:0] | b_out[15:8], 8'h00);

        // stored transfer right after reset shows cleared registers
        @(negedge clk);
        ab_en = 2'b11; ab_sel = 2'b11; ba_en_n = 2'b00; ba_sel = 2'b11;
        settle();
        for (int h = 0; h < 2; h++) begin
            check($sformatf("R9 cleared A reg half%0d", h), b_out[h*8 +: 8], 8'h00);
            check($sformatf("R9 cleared B reg half%0d", h), a_out[h*8 +: 8], 8'h00);
        end

        // isolation, load distinct words from outside drivers
        @(negedge clk);
        ab_en = 2'b00; ba_en_n = 2'b11;
        ext_a = 16'hC35A; ext_b = 16'h2BE7; ext_a_on = 2'b11; ext_b_on = 2'b11;
        settle();
        capture(2'b11, 2'b11);

        // sweep all control combinations, halves on different combinations
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            for (int h = 0; h < 2; h++) begin
                logic [3:0] cfg;
                cfg = (h == 0) ? 4'(c) : 4'(15 - c);
                ab_en[h] = cfg[0]; ba_en_n[h] = cfg[1];
                ab_sel[h] = cfg[2]; ba_sel[h] = cfg[3];
                ext_a[h*8 +: 8] = 8'(c * 17 + h * 5 + 3);
                ext_b[h*8 +: 8] = 8'(~(c * 29 + h));
                ext_a_on[h] = cfg[1] | (cfg[0] & ~cfg[2] & ~cfg[3]);
                ext_b_on[h] = ~cfg[0];
            end
            settle();
            for (int h = 0; h < 2; h++) begin
                expect_bus(ab_en[h], ba_en_n[h], ab_sel[h], ba_sel[h],
                           ext_a[h*8 +: 8], ext_b[h*8 +: 8], ma[h], mb[h], xa, xb);
                check($sformatf("R3 R8 bus A half%0d combo%0d", h, c), a_in[h*8 +: 8], xa);
                check($sformatf("R3 R8 bus B half%0d combo%0d", h, c), b_in[h*8 +: 8], xb);
                check($sformatf("R1 b_oe half%0d combo%0d", h, c), {7'b0, b_oe[h]}, {7'b0, ab_en[h]});
                check($sformatf("R2 a_oe half%0d combo%0d", h, c), {7'b0, a_oe[h]}, {7'b0, ~ba_en_n[h]});
                if (!ab_en[h])
                    check($sformatf("R1 b_out quiet half%0d", h), b_out[h*8 +: 8], 8'h00);
                if (ba_en_n[h])
                    check($sformatf("R2 a_out quiet half%0d", h), a_out[h*8 +: 8], 8'h00);
            end
        end

        // live A to B, then close the loop and release the outside driver
        @(negedge clk);
        ab_en = 2'b11; ab_sel = 2'b00; ba_en_n = 2'b11; ba_sel = 2'b00;
        ext_a = 16'h3C3C; ext_a_on = 2'b11; ext_b_on = 2'b00;
        settle();
        @(negedge clk);
        ba_en_n = 2'b00; ext_a_on = 2'b00; ext_a = 16'hFFFF;
        settle();
        repeat (2) @(negedge clk);
        settle();
        for (int h = 0; h < 2; h++) begin
            check($sformatf("R7 held A half%0d", h), a_in[h*8 +: 8], 8'h3C);
            check($sformatf("R7 held B half%0d", h), b_in[h*8 +: 8], 8'h3C);
        end

        // one A word into both registers on a single edge
        @(negedge clk);
        ba_en_n = 2'b11; ext_a = 16'h9696; ext_a_on = 2'b11;
        settle();
        capture(2'b11, 2'b11);
        @(negedge clk);
        ab_sel = 2'b11; ba_en_n = 2'b00; ba_sel = 2'b11; ext_a_on = 2'b00;
        settle();
        for (int h = 0; h < 2; h++) begin
            check($sformatf("R6 A reg half%0d", h), b_out[h*8 +: 8], 8'h96);
            check($sformatf("R6 B reg half%0d", h), a_out[h*8 +: 8], 8'h96);
        end

        // distinct words, then stored mode with a staggered single load
        @(negedge clk);
        ab_en = 2'b00; ba_en_n = 2'b11;
        ext_a = 16'h1111; ext_b = 16'h2222; ext_a_on = 2'b11; ext_b_on = 2'b11;
        settle();
        capture(2'b11, 2'b11);
        @(negedge clk);
        ab_en = 2'b11; ab_sel = 2'b11; ba_en_n = 2'b00; ba_sel = 2'b11;
        ext_a_on = 2'b00; ext_b_on = 2'b00;
        settle();
        check("R3 stored both A", a_in[7:0], 8'h22);
        check("R3 stored both B", b_in[7:0], 8'h11);
        capture(2'b01, 2'b00);
        check("R4 A reg took driven A half0", b_out[7:0], 8'h22);
        check("R8 half1 A reg untouched", b_out[15:8], 8'h11);
        check("R5 B reg kept half0", a_out[7:0], 8'h22);

        // select switch within one cycle, then B capture while driving
        @(negedge clk);
        ba_sel = 2'b00;
        settle();
        check("R3 select to live half1 A", a_in[15:8], 8'h11);
        @(negedge clk);
        ba_en_n = 2'b11; ab_en = 2'b00; ext_b = 16'h5AA5; ext_b_on = 2'b11;
        settle();
        capture(2'b00, 2'b10);
        @(negedge clk);
        ext_b_on = 2'b00; ba_en_n = 2'b00; ba_sel = 2'b11;
        settle();
        check("R5 B reg load half1", a_out[15:8], 8'h5A);
        check("R5 B reg kept half0", a_out[7:0], 8'h22);

        // asynchronous clear mid-run
        #1 rst_n = 1'b0;
        #0.5;
        check("R9 async clear half1", a_out[15:8], 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        summary();
        $finish;
    end
endmodule